// File: doc/BRIEF.md
# Transceiver Reset and Power-Down Sequencer

This block brings a serial transceiver block out of power-down and reset in a safe order. After the system reset it waits until the reconfiguration controller's busy flag is low. Busy going low shows that receiver offset cancellation has finished. Only then does the block pulse the block-wide power-down for a minimum time. The pulse length comes from a clock-frequency parameter and a nanosecond parameter.

After the pulse, the releases are staged. The PLL reset is held for a fixed number of cycles and is then released once busy is low. The sequencer then waits for PLL lock and frees the transmit digital reset, followed by the receiver analog reset. It then waits for CDR frequency lock. The receiver digital reset is released only after frequency lock has stayed high for a lock-to-data settle interval.

Both lock flags come from other clock domains and pass through two-flop synchronizers. If a lock is lost, the sequencer falls back to the matching earlier step and asserts the downstream resets again. A ready output marks the fully running state.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, the four reset outputs are 1, and `pwrdn_o` and `ready_o` are 0.
- R2: `pwrdn_o` stays 0 for as long as `busy_i` is 1 after reset. The pulse starts on the first clock edge at which `busy_i` is seen as 0.
- R3: The `pwrdn_o` pulse lasts exactly PD_CYC = ceil(PD_NS × CLK_HZ / 10^9) cycles. All four reset outputs stay 1 throughout the pulse.
- R4: After the pulse, `pll_rst_o` stays 1 for exactly PLL_RST_CYC cycles when `busy_i` is 0. It stays 1 beyond that for as long as `busy_i` is 1.
- R5: `tx_dig_rst_o` falls 3 cycles after `pll_locked_i` rises (two synchronizer flops plus one state step). `rx_ana_rst_o` falls exactly one cycle after `tx_dig_rst_o`. With no lock, both stay 1.
- R6: `rx_dig_rst_o` falls LTD_CYC + 3 cycles after `rx_freqlock_i` rises, where LTD_CYC = ceil(LTD_NS × CLK_HZ / 10^9). If frequency lock drops before then, `rx_dig_rst_o` stays 1 and the settle interval restarts on the next lock.
- R7: Losing frequency lock after release sets `rx_dig_rst_o` to 1 within 3 cycles. The PLL, transmit and receiver analog resets stay 0.
- R8: Losing PLL lock sets the PLL, transmit, receiver analog and receiver digital resets to 1 within 3 cycles. The sequence restarts from the PLL reset step, including the busy wait, with no new power-down pulse.
- R9: `ready_o` is 1 only when all four resets and `pwrdn_o` are 0 and both synchronized lock flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Reconfiguration / offset-cancellation busy flag |
| pll_locked_i | input | 1 | Transmit PLL lock (asynchronous) |
| rx_freqlock_i | input | 1 | Receiver CDR frequency lock (asynchronous) |
| pwrdn_o | output | 1 | Transceiver block power-down |
| pll_rst_o | output | 1 | PLL analog reset |
| tx_dig_rst_o | output | 1 | Transmit digital reset |
| rx_ana_rst_o | output | 1 | Receiver analog reset |
| rx_dig_rst_o | output | 1 | Receiver digital reset |
| ready_o | output | 1 | Transceiver fully out of reset and locked |

## Verification
The assertions check these properties on every cycle:
- The release order of the reset chain.
- The lower bound on the power-down pulse width.
- Power-down never starts while busy is high.
- The resets stay held during power-down.
- The receiver digital reset falls only after a full stretch of settled frequency lock.

Some behaviours can only be shown by the bench's scenarios, because they depend on chosen input histories:
- The exact cycle counts of each stage, including the rounding of the nanosecond parameters.
- The restart of the settle interval after interrupted locks of many lengths.
- The fallback paths after each kind of lock loss.
- Holding the PLL reset during a later busy period.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    typedef enum logic [2:0] {
        ST_CAL_WAIT = 3'd0,
        ST_PWRDN    = 3'd1,
        ST_PLL_RST  = 3'd2,
        ST_PLL_WAIT = 3'd3,
        ST_RXA_REL  = 3'd4,
        ST_FL_WAIT  = 3'd5,
        ST_SETTLE   = 3'd6,
        ST_RUN      = 3'd7
    } xrs_state_e;

    typedef struct packed {
        logic pwrdn;
        logic pll_rst;
        logic tx_rst;
        logic rxa_rst;
        logic rxd_rst;
    } xrs_outs_t;

    // ceil(ns * hz / 1e9), never below one cycle
    function automatic int ns_to_cyc(input longint hz, input longint ns);
        longint c;
        c = (hz * ns + 64'sd999_999_999) / 64'sd1_000_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic xrs_outs_t decode(input xrs_state_e s);
        xrs_outs_t o;
        o = '{pwrdn: 1'b0, pll_rst: 1'b1, tx_rst: 1'b1, rxa_rst: 1'b1, rxd_rst: 1'b1};
        case (s)
            ST_PWRDN:    o.pwrdn   = 1'b1;
            ST_PLL_WAIT: o.pll_rst = 1'b0;
            ST_RXA_REL: begin
                o.pll_rst = 1'b0;
                o.tx_rst  = 1'b0;
            end
            ST_FL_WAIT, ST_SETTLE: begin
                o.pll_rst = 1'b0;
                o.tx_rst  = 1'b0;
                o.rxa_rst = 1'b0;
            end
            ST_RUN: begin
                o.pll_rst = 1'b0;
                o.tx_rst  = 1'b0;
                o.rxa_rst = 1'b0;
                o.rxd_rst = 1'b0;
            end
            default: ;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta, stab;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta <= 1'b0;
                stab <= 1'b0;
            end else begin
                meta <= d[i];
                stab <= meta;
            end
        end
        assign q[i] = stab;
    end
endmodule

// File: rtl/xrs_timer.sv
module xrs_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] len,
    output logic          done
);
    logic [TW-1:0] cnt;

    // load with len: done is seen len-1 cycles later, so the owning state lasts len cycles
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= len - TW'(1);
        else if (cnt != '0)
            cnt <= cnt - TW'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
    import xrs_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int PD_NS       = 1000,
    parameter int LTD_NS      = 4000,
    parameter int PLL_RST_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    input  logic pll_locked_i,
    input  logic rx_freqlock_i,
    output logic pwrdn_o,
    output logic pll_rst_o,
    output logic tx_dig_rst_o,
    output logic rx_ana_rst_o,
    output logic rx_dig_rst_o,
    output logic ready_o
);
    localparam int PD_CYC  = ns_to_cyc(longint'(CLK_HZ), longint'(PD_NS));
    localparam int LTD_CYC = ns_to_cyc(longint'(CLK_HZ), longint'(LTD_NS));
    localparam int TMAX    = max3(PD_CYC, LTD_CYC, PLL_RST_CYC);
    localparam int TW      = $clog2(TMAX + 1);

    logic [1:0] lock_raw, lock_s;
    logic       pll_s, fl_s;

    assign lock_raw = {rx_freqlock_i, pll_locked_i};

    xrs_sync #(.W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (lock_raw),
        .q   (lock_s)
    );
    assign pll_s = lock_s[0];
    assign fl_s  = lock_s[1];

    xrs_state_e    state, state_nx;
    logic          t_load, t_done;
    logic [TW-1:0] t_len;

    xrs_timer #(.TW(TW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (t_load),
        .len  (t_len),
        .done (t_done)
    );

    always_comb begin
        state_nx = state;
        t_load   = 1'b0;
        t_len    = TW'(PLL_RST_CYC);
        case (state)
            ST_CAL_WAIT: if (!busy_i) begin
                state_nx = ST_PWRDN;
                t_load   = 1'b1;
                t_len    = TW'(PD_CYC);
            end
            ST_PWRDN: if (t_done) begin
                state_nx = ST_PLL_RST;
                t_load   = 1'b1;
                t_len    = TW'(PLL_RST_CYC);
            end
            ST_PLL_RST: if (t_done && !busy_i) state_nx = ST_PLL_WAIT;
            ST_PLL_WAIT: if (pll_s) state_nx = ST_RXA_REL;
            ST_RXA_REL, ST_FL_WAIT, ST_SETTLE, ST_RUN: begin
                if (!pll_s) begin
                    state_nx = ST_PLL_RST;
                    t_load   = 1'b1;
                    t_len    = TW'(PLL_RST_CYC);
                end else begin
                    case (state)
                        ST_RXA_REL: state_nx = ST_FL_WAIT;
                        ST_FL_WAIT: if (fl_s) begin
                            state_nx = ST_SETTLE;
                            t_load   = 1'b1;
                            t_len    = TW'(LTD_CYC);
                        end
                        ST_SETTLE: begin
                            if (!fl_s)       state_nx = ST_FL_WAIT;
                            else if (t_done) state_nx = ST_RUN;
                        end
                        default: if (!fl_s) state_nx = ST_FL_WAIT;
                    endcase
                end
            end
            default: state_nx = ST_CAL_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_CAL_WAIT;
        else     state <= state_nx;
    end

    xrs_outs_t outs;
    assign outs         = decode(state);
    assign pwrdn_o      = outs.pwrdn;
    assign pll_rst_o    = outs.pll_rst;
    assign tx_dig_rst_o = outs.tx_rst;
    assign rx_ana_rst_o = outs.rxa_rst;
    assign rx_dig_rst_o = outs.rxd_rst;
    assign ready_o      = (state == ST_RUN) && pll_s && fl_s;
endmodule

// File: rtl/xrs_chk.sv
module xrs_chk #(
    parameter int PD_CYC  = 50,
    parameter int LTD_CYC = 200
) (
    input logic clk,
    input logic rst,
    input logic busy_i,
    input logic pwrdn_o,
    input logic pll_rst_o,
    input logic tx_dig_rst_o,
    input logic rx_ana_rst_o,
    input logic rx_dig_rst_o,
    input logic ready_o,
    input logic fl_sync
);
    int pd_len, fl_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_len <= 0;
            fl_len <= 0;
        end else begin
            pd_len <= pwrdn_o ? ((pd_len < PD_CYC) ? pd_len + 1 : pd_len) : 0;
            fl_len <= fl_sync ? ((fl_len < LTD_CYC) ? fl_len + 1 : fl_len) : 0;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pll_rst_o && tx_dig_rst_o && rx_ana_rst_o && rx_dig_rst_o && !pwrdn_o && !ready_o));

    a_r2_pd_after_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(pwrdn_o) |-> !$past(busy_i));

    a_r3_pd_holds_resets: assert property (@(posedge clk) disable iff (rst)
        pwrdn_o |-> (pll_rst_o && tx_dig_rst_o && rx_ana_rst_o && rx_dig_rst_o));

    a_r3_pd_min_width: assert property (@(posedge clk) disable iff (rst)
        $fell(pwrdn_o) |-> (pd_len >= PD_CYC));

    a_r5_tx_after_pll: assert property (@(posedge clk) disable iff (rst)
        !tx_dig_rst_o |-> !pll_rst_o);

    a_r5_rxa_after_tx: assert property (@(posedge clk) disable iff (rst)
        !rx_ana_rst_o |-> !tx_dig_rst_o);

    a_r6_rxd_after_rxa: assert property (@(posedge clk) disable iff (rst)
        !rx_dig_rst_o |-> !rx_ana_rst_o);

    a_r6_settle_len: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_dig_rst_o) |-> (fl_len >= LTD_CYC));

    a_r9_ready_clean: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> !(pwrdn_o || pll_rst_o || tx_dig_rst_o || rx_ana_rst_o || rx_dig_rst_o));
endmodule

bind xcvr_rst_seq xrs_chk #(.PD_CYC(PD_CYC), .LTD_CYC(LTD_CYC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy_i       (busy_i),
    .pwrdn_o      (pwrdn_o),
    .pll_rst_o    (pll_rst_o),
    .tx_dig_rst_o (tx_dig_rst_o),
    .rx_ana_rst_o (rx_ana_rst_o),
    .rx_dig_rst_o (rx_dig_rst_o),
    .ready_o      (ready_o),
    .fl_sync      (fl_s)
);

// File: tb/test_xcvr_rst_seq.sv
module test_xcvr_rst_seq;
    localparam int CLK_HZ = 50_000_000;
    localparam int PD_NS  = 1010;
    localparam int LTD_NS = 610;
    localparam int PRC    = 6;
    localparam longint GIGA = 64'sd1_000_000_000;
    localparam int PD_EXP  = int'((longint'(CLK_HZ) * PD_NS + GIGA - 1) / GIGA);
    localparam int LTD_EXP = int'((longint'(CLK_HZ) * LTD_NS + GIGA - 1) / GIGA);

    logic clk = 1'b0;
    logic rst, busy, pll, fl;
    logic pwrdn, pllr, txr, rxar, rxdr, rdy;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xcvr_rst_seq #(
        .CLK_HZ(CLK_HZ), .PD_NS(PD_NS), .LTD_NS(LTD_NS), .PLL_RST_CYC(PRC)
    ) i_xcvr_rst_seq (
        .clk(clk), .rst(rst), .busy_i(busy), .pll_locked_i(pll), .rx_freqlock_i(fl),
        .pwrdn_o(pwrdn), .pll_rst_o(pllr), .tx_dig_rst_o(txr),
        .rx_ana_rst_o(rxar), .rx_dig_rst_o(rxdr), .ready_o(rdy)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int outvec();
        return {pwrdn, pllr, txr, rxar, rxdr, rdy};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int n, bad;
        int ks[5];
        rst = 1'b1; busy = 1'b1; pll = 1'b0; fl = 1'b0;
        repeat (4) tick();
        // R1: reset state {pwrdn,pll,tx,rxa,rxd,ready} = 011110
        chk(outvec() == 6'b011110, "R1 reset outputs", outvec(), 6'b011110);
        rst = 1'b0;
        tick();
        chk(outvec() == 6'b011110, "R1 after reset", outvec(), 6'b011110);

        // R2: no power-down while busy
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (pwrdn) bad++;
        end
        chk(bad == 0, "R2 pwrdn while busy", bad, 0);
        busy = 1'b0;
        n = 0;
        while (!pwrdn && n < 10) begin tick(); n++; end
        chk(n == 1, "R2 pulse start delay", n, 1);

        // R3: pulse width and held resets
        n = 0; bad = 0;
        while (pwrdn && n < 1000) begin
            if (!(pllr && txr && rxar && rxdr)) bad++;
            n++; tick();
        end
        chk(n == PD_EXP, "R3 pwrdn width", n, PD_EXP);
        chk(bad == 0, "R3 resets during pwrdn", bad, 0);

        // R4: PLL reset hold
        n = 0;
        while (pllr && n < 1000) begin n++; tick(); end
        chk(n == PRC, "R4 pll reset width", n, PRC);

        // R5: without lock, tx and rx analog stay held
        repeat (5) tick();
        chk(txr && rxar && rxdr, "R5 held without pll lock", {txr, rxar, rxdr}, 3'b111);
        pll = 1'b1;
        n = 0;
        do begin tick(); n++; end while (txr && n < 50);
        chk(n == 3, "R5 tx release latency", n, 3);
        chk(rxar == 1'b1, "R5 rx analog after tx", rxar, 1);
        tick();
        chk(rxar == 1'b0, "R5 rx analog release", rxar, 0);

        repeat (5) tick();
        chk(rxdr && !rdy, "R6 rxd held without freq lock", {rxdr, rdy}, 2'b10);

        // R6: interrupted frequency locks never release rx digital reset
        ks = '{1, 2, 4, LTD_EXP / 2, LTD_EXP - 1};
        foreach (ks[j]) begin
            bad = 0;
            fl = 1'b1;
            for (int i = 0; i < ks[j]; i++) begin tick(); if (!rxdr) bad++; end
            fl = 1'b0;
            for (int i = 0; i < 6; i++) begin tick(); if (!rxdr) bad++; end
            chk(bad == 0, "R6 early release", bad, 0);
        end

        fl = 1'b1;
        n = 0;
        do begin tick(); n++; end while (rxdr && n < 1000);
        chk(n == LTD_EXP + 3, "R6 settle latency", n, LTD_EXP + 3);
        // R9: ready with all clear
        chk(outvec() == 6'b000001, "R9 ready state", outvec(), 6'b000001);

        // R7: frequency lock loss
        fl = 1'b0;
        repeat (3) tick();
        chk(outvec() == 6'b000010, "R7 fl loss outputs", outvec(), 6'b000010);
        fl = 1'b1;
        n = 0;
        do begin tick(); n++; end while (rxdr && n < 1000);
        chk(n == LTD_EXP + 3, "R6 settle after R7", n, LTD_EXP + 3);
        chk(rdy == 1'b1, "R9 ready again", rdy, 1);

        // R8: PLL lock loss with busy held by a reconfiguration
        busy = 1'b1; pll = 1'b0;
        repeat (3) tick();
        chk(outvec() == 6'b011110, "R8 pll loss outputs", outvec(), 6'b011110);
        bad = 0;
        for (int i = 0; i < 3 * PRC; i++) begin tick(); if (!pllr || pwrdn) bad++; end
        chk(bad == 0, "R8 R4 pll reset held while busy", bad, 0);
        busy = 1'b0;
        n = 0;
        while (pllr && n < 50) begin tick(); n++; end
        chk(n == 1, "R4 release after busy", n, 1);
        pll = 1'b1;
        n = 0; bad = 0;
        while (!rdy && n < 1000) begin tick(); n++; if (pwrdn) bad++; end
        chk(n == 4 + LTD_EXP + 1, "R8 relock latency", n, 4 + LTD_EXP + 1);
        chk(bad == 0, "R8 no new pwrdn", bad, 0);
        chk(outvec() == 6'b000001, "R9 final ready", outvec(), 6'b000001);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule